// File: doc/BRIEF.md
# Reset-Time Clock Ratio Strap Driver

This block owns four processor input pins that are shared between two uses. During reset they carry a code that tells the processor which core-to-bus clock ratio to use. The rest of the time they carry the system's own non-maskable interrupt, maskable interrupt, numeric-error-ignore and address-wrap control signals. The block selects between the two sources for each pin. It also keeps the configuration field that software later reads back for the chosen ratio.

The ratio select is sampled on every bus clock edge while reset is asserted. When reset is removed, that value is frozen. The strap code stays on the pins for a parameterised number of bus clocks and then the pins return to system logic. If the select is unknown, or asks for a ratio above the rated maximum, the block falls back to the lowest ratio and raises an error flag. A monitor counts reset pulse width in bus clocks. It flags any pulse shorter than the minimum, which by default is 1 ms at a 15 ns bus clock. A low power-good input acts as a full reset of the block.

There is no streaming data path, so every port is a plain level signal. No valid/ready handshake or back-pressure applies.

Top module: `ratio_strap_mux`

## Requirements
- R1: While `rst_req` is high, the pin vector {`pin_nmi`,`pin_intr`,`pin_ignne`,`pin_a20m`} carries the strap code of the captured ratio: 4'b0001 for ratio 4 and 4'b0011 for ratio 5 (1 means electrically high).
- R2: `cfg_ratio_bits` reads 4'b0010 for ratio 4 and 4'b0000 for ratio 5. It is reloaded from `ratio_sel` on every bus clock edge where `rst_req` is high and does not change on any other edge.
- R3: `ratio_sel` value 0 selects ratio 4 and value 1 selects ratio 5. Ratio 5 is valid only when parameter MAX_RATIO is at least 5. Any other value, or a ratio above MAX_RATIO, captures ratio 4 with `ratio_err` high. A valid select captures `ratio_err` low.
- R4: After `rst_req` falls, the strap code stays on the pins for exactly HOLD_CLKS bus clock rising edges.
- R5: When neither reset nor the hold window is active, each pin equals its system input, bit for bit.
- R6: Raising `rst_req` puts the strap code on the pins at once, without waiting for a clock edge.
- R7: `rst_too_short` is set on the first edge that samples `rst_req` low after a pulse that covered fewer than MIN_RST_CLKS rising edges. It is cleared to 0 on the first edge of the next pulse and is 0 after a pulse that was long enough.
- R8: While `pwr_ok` is low, the block is held in reset: `cfg_ratio_bits` is 4'b0010, `ratio_err` and `rst_too_short` are 0, the pins carry the ratio 4 strap code, and no reset edges are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| rst_req | input | 1 | Processor reset, active high, asynchronous rise, synchronous fall |
| pwr_ok | input | 1 | Power-good; low resets the block asynchronously |
| sys_nmi | input | 1 | System non-maskable interrupt |
| sys_intr | input | 1 | System maskable interrupt |
| sys_ignne | input | 1 | System numeric-error-ignore control |
| sys_a20m | input | 1 | System address-wrap mask control |
| ratio_sel | input | SEL_W | Requested clock ratio select |
| pin_nmi | output | 1 | Drive for the shared interrupt pin |
| pin_intr | output | 1 | Drive for the shared maskable interrupt pin |
| pin_ignne | output | 1 | Drive for the shared numeric-error pin |
| pin_a20m | output | 1 | Drive for the shared address-wrap pin |
| cfg_ratio_bits | output | 4 | Captured configuration field for the ratio |
| ratio_err | output | 1 | Captured select was invalid; fallback used |
| rst_too_short | output | 1 | Last reset pulse was shorter than the minimum |

## Verification
The assertions check on every cycle that:
- reset and the hold window always show a strap code that matches the captured configuration field;
- the configuration field is one of the two legal codes and stays frozen on edges without reset;
- an error always comes with the fallback code;
- the short-pulse flag only rises after a release.

The exact hold length, the asynchronous switch to the strap code in mid-cycle, the pulse-width threshold and the rated-maximum fallback depend on timing and parameters. Only the bench scenarios show those, comparing each clock against its reference model.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Pin order {nmi, intr, ignne, a20m}; cfg is the software-visible field.
  typedef struct packed {
    logic [3:0] pins;
    logic [3:0] cfg;
  } strap_code_t;

  localparam strap_code_t CODE_X4 = '{pins: 4'b0001, cfg: 4'b0010};
  localparam strap_code_t CODE_X5 = '{pins: 4'b0011, cfg: 4'b0000};

endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
  import strap_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MAX_RATIO = 5
) (
  input  logic [SEL_W-1:0] sel,
  output strap_code_t      code,
  output logic             bad
);
  logic x5_allowed;
  logic pick_x4, pick_x5;

  generate
    if (MAX_RATIO >= 5) begin : g_x5_ok
      assign x5_allowed = 1'b1;
    end else begin : g_x5_capped
      assign x5_allowed = 1'b0;
    end
  endgenerate

  assign pick_x4 = (sel == SEL_W'(0));
  assign pick_x5 = (sel == SEL_W'(1)) && x5_allowed;
  assign bad     = !(pick_x4 || pick_x5);
  assign code    = pick_x5 ? CODE_X5 : CODE_X4;
endmodule

// File: rtl/strap_hold_timer.sv
module strap_hold_timer #(
  parameter int HOLD_CLKS = 4
) (
  input  logic clk,
  input  logic rst_async,
  output logic active
);
  generate
    if (HOLD_CLKS == 0) begin : g_no_hold
      assign active = rst_async;
    end else begin : g_hold
      localparam int HW = $clog2(HOLD_CLKS + 1);
      logic [HW-1:0] left;
      always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async)          left <= HW'(HOLD_CLKS);
        else if (left != '0)    left <= left - 1'b1;
      end
      assign active = rst_async || (left != '0);
    end
  endgenerate
endmodule

// File: rtl/rst_width_mon.sv
module rst_width_mon #(
  parameter int MIN_CLKS = 66667
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic rst_req,
  output logic too_short
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      seen      <= '0;
      too_short <= 1'b0;
    end else if (rst_req) begin
      too_short <= 1'b0;
      if (seen != CW'(MIN_CLKS)) seen <= seen + 1'b1;
    end else if (seen != '0) begin
      too_short <= (seen < CW'(MIN_CLKS));
      seen      <= '0;
    end
  end
endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
  parameter int N = 4
) (
  input  logic         strap_en,
  input  logic [N-1:0] strap_val,
  input  logic [N-1:0] sys_val,
  output logic [N-1:0] pin
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pin[i] = strap_en ? strap_val[i] : sys_val[i];
  end
endmodule

// File: rtl/ratio_strap_mux.sv
module ratio_strap_mux
  import strap_pkg::*;
#(
  parameter int SEL_W        = 3,
  parameter int MAX_RATIO    = 5,
  parameter int HOLD_CLKS    = 4,
  parameter int MIN_RST_CLKS = 66667
) (
  input  logic             bclk,
  input  logic             rst_req,
  input  logic             pwr_ok,
  input  logic             sys_nmi,
  input  logic             sys_intr,
  input  logic             sys_ignne,
  input  logic             sys_a20m,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             pin_nmi,
  output logic             pin_intr,
  output logic             pin_ignne,
  output logic             pin_a20m,
  output logic [3:0]       cfg_ratio_bits,
  output logic             ratio_err,
  output logic             rst_too_short
);
  logic        rst_all;
  logic        strap_act;
  strap_code_t dec_code;
  logic        dec_bad;
  strap_code_t cap_code;
  logic        cap_bad;
  logic [3:0]  pin_vec;

  assign rst_all = rst_req || !pwr_ok;

  ratio_decode #(.SEL_W(SEL_W), .MAX_RATIO(MAX_RATIO)) u_dec (
    .sel (ratio_sel),
    .code(dec_code),
    .bad (dec_bad)
  );

  always_ff @(posedge bclk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      cap_code <= CODE_X4;
      cap_bad  <= 1'b0;
    end else if (rst_req) begin
      cap_code <= dec_code;
      cap_bad  <= dec_bad;
    end
  end

  strap_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk      (bclk),
    .rst_async(rst_all),
    .active   (strap_act)
  );

  rst_width_mon #(.MIN_CLKS(MIN_RST_CLKS)) u_width (
    .clk      (bclk),
    .pwr_ok   (pwr_ok),
    .rst_req  (rst_req),
    .too_short(rst_too_short)
  );

  pin_mux #(.N(4)) u_mux (
    .strap_en (strap_act),
    .strap_val(cap_code.pins),
    .sys_val  ({sys_nmi, sys_intr, sys_ignne, sys_a20m}),
    .pin      (pin_vec)
  );

  assign {pin_nmi, pin_intr, pin_ignne, pin_a20m} = pin_vec;
  assign cfg_ratio_bits = cap_code.cfg;
  assign ratio_err      = cap_bad;
endmodule

// File: rtl/ratio_strap_mux_chk.sv
module ratio_strap_mux_chk (
  input logic       bclk,
  input logic       pwr_ok,
  input logic       rst_req,
  input logic       strap_act,
  input logic [3:0] pins,
  input logic [3:0] cfg,
  input logic       err,
  input logic       short_flag
);
  assert_strap_matches_cfg_R1: assert property (@(posedge bclk) disable iff (!pwr_ok)
    strap_act |-> (pins == ((cfg == 4'b0010) ? 4'b0001 : 4'b0011)));

  assert_cfg_legal_R2: assert property (@(posedge bclk) disable iff (!pwr_ok)
    (cfg == 4'b0010) || (cfg == 4'b0000));

  assert_cfg_frozen_R2: assert property (@(posedge bclk) disable iff (!pwr_ok)
    !rst_req |=> $stable(cfg));

  assert_err_fallback_R3: assert property (@(posedge bclk) disable iff (!pwr_ok)
    err |-> (cfg == 4'b0010));

  assert_reset_opens_window_R4: assert property (@(posedge bclk) disable iff (!pwr_ok)
    rst_req |-> strap_act);

  assert_short_after_release_R7: assert property (@(posedge bclk) disable iff (!pwr_ok)
    $rose(short_flag) |-> !$past(rst_req));
endmodule

bind ratio_strap_mux ratio_strap_mux_chk chk_i (
  .bclk      (bclk),
  .pwr_ok    (pwr_ok),
  .rst_req   (rst_req),
  .strap_act (strap_act),
  .pins      ({pin_nmi, pin_intr, pin_ignne, pin_a20m}),
  .cfg       (cfg_ratio_bits),
  .err       (ratio_err),
  .short_flag(rst_too_short)
);

// File: tb/ratio_strap_mux_tb_top.sv
module ratio_strap_mux_tb_top;
  localparam int HOLD = 3;
  localparam int MINW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_req, pwr_ok;
  logic [3:0] sys;
  logic [2:0] sel;
  logic       p_nmi, p_intr, p_ignne, p_a20m;
  logic [3:0] cfg;
  logic       err, shrt;
  logic       l_nmi, l_intr, l_ignne, l_a20m;
  logic [3:0] l_cfg;
  logic       l_err, l_shrt;

  ratio_strap_mux #(.SEL_W(3), .MAX_RATIO(5), .HOLD_CLKS(HOLD), .MIN_RST_CLKS(MINW)) dut_i (
    .bclk(clk), .rst_req(rst_req), .pwr_ok(pwr_ok),
    .sys_nmi(sys[3]), .sys_intr(sys[2]), .sys_ignne(sys[1]), .sys_a20m(sys[0]),
    .ratio_sel(sel),
    .pin_nmi(p_nmi), .pin_intr(p_intr), .pin_ignne(p_ignne), .pin_a20m(p_a20m),
    .cfg_ratio_bits(cfg), .ratio_err(err), .rst_too_short(shrt));

  ratio_strap_mux #(.SEL_W(3), .MAX_RATIO(4), .HOLD_CLKS(HOLD), .MIN_RST_CLKS(MINW)) dut_lim_i (
    .bclk(clk), .rst_req(rst_req), .pwr_ok(pwr_ok),
    .sys_nmi(sys[3]), .sys_intr(sys[2]), .sys_ignne(sys[1]), .sys_a20m(sys[0]),
    .ratio_sel(sel),
    .pin_nmi(l_nmi), .pin_intr(l_intr), .pin_ignne(l_ignne), .pin_a20m(l_a20m),
    .cfg_ratio_bits(l_cfg), .ratio_err(l_err), .rst_too_short(l_shrt));

  int checks = 0;
  int failures = 0;

  // Behavioural reference model
  bit m_x5, m_err, m_short;
  int m_hold, m_cnt;

  always @(posedge clk) begin
    if (!pwr_ok) begin
      m_x5 = 0; m_err = 0; m_short = 0; m_hold = HOLD; m_cnt = 0;
    end else if (rst_req) begin
      m_x5    = (sel == 3'd1);
      m_err   = (sel > 3'd1);
      m_hold  = HOLD;
      m_short = 0;
      if (m_cnt < MINW) m_cnt++;
    end else begin
      if (m_hold > 0) m_hold--;
      if (m_cnt != 0) begin
        m_short = (m_cnt < MINW);
        m_cnt   = 0;
      end
    end
  end

  function automatic logic [3:0] exp_strap();
    return (pwr_ok && m_x5) ? 4'b0011 : 4'b0001;
  endfunction

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [3:0] e_pins;
    string      tag;
    bit         strap;
    strap  = rst_req || !pwr_ok || (m_hold > 0);
    e_pins = strap ? exp_strap() : sys;
    if (!pwr_ok)      tag = "R8";
    else if (rst_req) tag = "R1";
    else if (strap)   tag = "R4";
    else              tag = "R5";
    check(tag, "pins", {p_nmi, p_intr, p_ignne, p_a20m}, e_pins);
    check(pwr_ok ? "R2" : "R8", "cfg", cfg, (pwr_ok && m_x5) ? 4'b0000 : 4'b0010);
    check(pwr_ok ? "R3" : "R8", "err", {3'b0, err}, {3'b0, pwr_ok && m_err});
    check(pwr_ok ? "R7" : "R8", "short", {3'b0, shrt}, {3'b0, pwr_ok && m_short});
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pwr_ok = 0; rst_req = 1; sel = 3'd0; sys = 4'b1010;
    cyc(3);
    // R8: reset state under power-good low
    check("R8", "reset cfg", cfg, 4'b0010);
    check("R8", "reset pins", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b0001);
    check("R8", "reset short", {3'b0, shrt}, 4'b0);

    // Long valid pulse, ratio 5
    pwr_ok = 1; sel = 3'd1;
    cyc(10);
    check("R1", "ratio5 pins", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b0011);
    rst_req = 0; sys = 4'b0100;
    cyc(1);
    check("R4", "hold after release", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b0011);
    check("R7", "long pulse no flag", {3'b0, shrt}, 4'b0);
    cyc(HOLD);
    check("R5", "pins back to system", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b0100);

    // R2: select changes outside reset are ignored
    sel = 3'd0;
    cyc(3);
    check("R2", "cfg frozen", cfg, 4'b0000);

    // R5: walk all system patterns
    for (int v = 0; v < 16; v++) begin
      sys = 4'(v);
      cyc(1);
    end

    // R6: asynchronous rise mid-cycle
    @(negedge clk);
    compare_all();
    sys = 4'b1100;
    #2 rst_req = 1;
    #1 check("R6", "async strap", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b0011);
    // Ratio changes inside reset, last one wins
    sel = 3'd0;
    cyc(4);
    sel = 3'd1;
    cyc(6);
    rst_req = 0;
    cyc(HOLD + 2);
    check("R2", "last select captured", cfg, 4'b0000);

    // Short pulse, invalid select
    rst_req = 1; sel = 3'd5;
    cyc(3);
    check("R3", "invalid falls back", cfg, 4'b0010);
    check("R3", "invalid error", {3'b0, err}, 4'b0001);
    rst_req = 0;
    cyc(1);
    check("R7", "short flag", {3'b0, shrt}, 4'b0001);
    cyc(HOLD + 2);

    // Rated maximum: ratio 5 rejected by capped instance
    rst_req = 1; sel = 3'd1;
    cyc(2);
    check("R7", "flag cleared on new pulse", {3'b0, shrt}, 4'b0);
    check("R3", "capped cfg", l_cfg, 4'b0010);
    check("R3", "capped err", {3'b0, l_err}, 4'b0001);
    check("R3", "uncapped err", {3'b0, err}, 4'b0);
    cyc(8);
    rst_req = 0;
    cyc(HOLD + 3);

    // R8: power-good drop outside reset
    pwr_ok = 0; sys = 4'b1111;
    #1 check("R8", "pg low cfg", cfg, 4'b0010);
    cyc(3);
    check("R8", "pg low pins", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b0001);
    pwr_ok = 1; rst_req = 1; sel = 3'd0;
    cyc(MINW);
    rst_req = 0;
    cyc(HOLD + 3);
    check("R7", "exact minimum ok", {3'b0, shrt}, 4'b0);
    check("R5", "final pins", {p_nmi, p_intr, p_ignne, p_a20m}, 4'b1111);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule